// File: doc/BRIEF.md
# AUX Burst Transfer Sequencer

The sequencer carries a byte block of any length between a requester and a sink's 20-bit address space. The work goes through a request/reply engine that handles one short transaction at a time. The requester gives a start pulse with a length, a start address, a direction and a transaction type. The sequencer then cuts the block into transactions of at most 16 bytes. For each transaction it places the address fields and the command byte, clears the engine's data buffer, fills it for writes, and launches the transaction. It then watches the engine's enable bit clear, waits for the reply flag and judges the outcome from the error flag and the status field.

A failed transaction is rebuilt and relaunched, up to ten attempts per chunk. Ten failures abort the whole transfer with an error pulse. After a successful read transaction, the received bytes are handed to the requester, each tagged with its offset in the transfer. Write bytes are pulled from the requester by offset while the buffer is filled. Time limits are kept in milliseconds, using a cycle prescaler whose length is a parameter.

Top module: `aux_burst_seq`

## Requirements
- R1: Each transaction carries min(remaining, 16) bytes. The command byte holds length-1 in bits 7:4.
- R2: The address of each transaction appears as bits 7:0 on `eng_addr_lo_o`, bits 15:8 on `eng_addr_mid_o` and bits 19:16 on `eng_addr_hi_o`. It starts at the requested address and advances by the chunk length after each successful transaction. Write bytes land at consecutive sink addresses.
- R3: Command bit 3 is 1 for a native transaction and 0 for an I2C-over-AUX transaction. Bit 0 is 1 for a read and 0 for a write. Bits 2:1 are 0.
- R4: Every launch, including a retry, is preceded by a buffer clear pulse. For writes, buffer positions 0..len-1 hold the chunk's bytes, in order, at launch.
- R5: An attempt fails if the enable bit stays set for the enable limit (20 ms ticks), or if no reply arrives within the reply limit (10 ms ticks) after the bit clears.
- R6: A received reply is cleared with a reply-clear pulse. If the error flag is set, an error-clear pulse is issued and the attempt fails. A nonzero status field also fails the attempt.
- R7: A chunk is attempted at most 10 times. After the 10th failure `err_o` pulses, no further launch happens, and no sink byte is changed by a failed write.
- R8: Read bytes reach the requester only after a successful attempt, on `data_we_o`, with `data_idx_o` equal to the byte's offset in the transfer.
- R9: `busy_o` is high from the cycle after an accepted start through the single cycle in which `done_o` or `err_o` pulses. Exactly one of the two pulses per transfer.
- R10: A zero length pulses `done_o` in the cycle after the start, with no launch.
- R11: A start pulse while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_start_i | input | 1 | Start a transfer (accepted when idle) |
| req_len_i | input | LEN_W | Transfer length in bytes |
| req_addr_i | input | 20 | Start address in the sink |
| req_write_i | input | 1 | 1 = write to sink, 0 = read |
| req_native_i | input | 1 | 1 = native transaction, 0 = I2C-over-AUX |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Abort pulse |
| data_rd_o | output | 1 | Write byte pulled at `data_idx_o` |
| data_we_o | output | 1 | Read byte delivered at `data_idx_o` |
| data_idx_o | output | LEN_W | Byte offset in the transfer |
| data_i | input | 8 | Write byte from the requester |
| data_o | output | 8 | Read byte to the requester |
| eng_clr_o | output | 1 | Clear engine data buffer |
| eng_buf_we_o | output | 1 | Buffer byte write |
| eng_buf_idx_o | output | log2(CHUNK_MAX) | Buffer position |
| eng_buf_wdata_o | output | 8 | Buffer write byte |
| eng_buf_rdata_i | input | 8 | Buffer byte at `eng_buf_idx_o` |
| eng_addr_lo_o | output | 8 | Address bits 7:0 |
| eng_addr_mid_o | output | 8 | Address bits 15:8 |
| eng_addr_hi_o | output | 4 | Address bits 19:16 |
| eng_cmd_o | output | 8 | Command byte |
| eng_launch_o | output | 1 | Set the engine's enable bit |
| eng_busy_i | input | 1 | Enable bit still set |
| eng_reply_i | input | 1 | Reply-received flag |
| eng_reply_clr_o | output | 1 | Clear reply flag |
| eng_err_i | input | 1 | Access-error flag |
| eng_err_clr_o | output | 1 | Clear access-error flag |
| eng_status_i | input | 4 | Reply status field, 0 = good |

## Verification
A wrong chunk or address counter shows at the very next launch, as a wrong address field or length code. A drifting pull offset shows as soon as the transaction's buffer contents are compared with the source bytes. A broken attempt counter shows at the end of the transfer, as a wrong launch count or the wrong final pulse. A read copy taken from a failed attempt shows as sentinel bytes overwritten in the requester's buffer. A broken timer shows as a hung transfer or a premature retry. This shows up only in the launch count, after the enable or reply limit has passed.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  localparam int unsigned ADDR_W = 20;

  typedef enum logic [3:0] {
    S_IDLE, S_CLEAR, S_LOAD, S_LAUNCH, S_WAIT_EN, S_WAIT_RPLY,
    S_CHECK, S_COPY, S_ADV, S_RETRY, S_DONE, S_FAIL
  } seq_state_e;

  // [7:4] length-1, [3] native, [2:1] zero, [0] read
  function automatic logic [7:0] aux_cmd(logic [3:0] len_m1, logic native, logic rd);
    return {len_m1, native, 2'b00, rd};
  endfunction
endpackage

// File: rtl/aux_chunk_track.sv
module aux_chunk_track #(
  parameter int unsigned LEN_W     = 12,
  parameter int unsigned CHUNK_MAX = 16,
  localparam int unsigned CW       = $clog2(CHUNK_MAX + 1)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            load_i,
  input  logic [LEN_W-1:0]                len_i,
  input  logic [aux_seq_pkg::ADDR_W-1:0]  addr_i,
  input  logic                            adv_i,
  output logic [LEN_W-1:0]                rem_o,
  output logic [aux_seq_pkg::ADDR_W-1:0]  addr_o,
  output logic [LEN_W-1:0]                base_o,
  output logic [CW-1:0]                   clen_o,
  output logic                            last_o
);
  logic [LEN_W-1:0]               rem_q, base_q;
  logic [aux_seq_pkg::ADDR_W-1:0] addr_q;

  assign clen_o = (rem_q >= LEN_W'(CHUNK_MAX)) ? CW'(CHUNK_MAX) : CW'(rem_q);
  assign last_o = rem_q <= LEN_W'(CHUNK_MAX);
  assign rem_o  = rem_q;
  assign addr_o = addr_q;
  assign base_o = base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
    end else if (load_i) begin
      rem_q  <= len_i;
      base_q <= '0;
      addr_q <= addr_i;
    end else if (adv_i) begin
      rem_q  <= rem_q - LEN_W'(clen_o);
      base_q <= base_q + LEN_W'(clen_o);
      addr_q <= addr_q + aux_seq_pkg::ADDR_W'(clen_o);
    end
  end

  // R1
  adv_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rem_q != '0);
endmodule

// File: rtl/aux_ms_timer.sv
module aux_ms_timer #(
  parameter int unsigned TICK_CYC = 1000,
  parameter int unsigned MS_MAX   = 20,
  localparam int unsigned PW      = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1,
  localparam int unsigned MSW     = $clog2(MS_MAX + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic [MSW-1:0] limit_i,
  output logic           expired_o
);
  logic [PW-1:0]  presc_q;
  logic [MSW-1:0] ms_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      ms_q    <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
      ms_q    <= '0;
    end else if (ms_q != MSW'(MS_MAX)) begin
      if (presc_q == PW'(TICK_CYC - 1)) begin
        presc_q <= '0;
        ms_q    <= ms_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end

  assign expired_o = ms_q >= limit_i;

  // R5
  ms_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ms_q <= MSW'(MS_MAX));
endmodule

// File: rtl/aux_retry_ctr.sv
module aux_retry_ctr #(
  parameter int unsigned MAX_TRY = 10,
  localparam int unsigned TW     = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = cnt_q == TW'(MAX_TRY - 1);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> cnt_q < TW'(MAX_TRY - 1));
endmodule

// File: rtl/aux_burst_seq.sv
module aux_burst_seq
  import aux_seq_pkg::*;
#(
  parameter int unsigned LEN_W       = 12,
  parameter int unsigned CHUNK_MAX   = 16,
  parameter int unsigned MAX_TRY     = 10,
  parameter int unsigned TICK_CYC    = 1000,
  parameter int unsigned EN_TMO_MS   = 20,
  parameter int unsigned RPLY_TMO_MS = 10,
  localparam int unsigned IW         = $clog2(CHUNK_MAX),
  localparam int unsigned CW         = $clog2(CHUNK_MAX + 1),
  localparam int unsigned MS_MAX     = (EN_TMO_MS > RPLY_TMO_MS) ? EN_TMO_MS : RPLY_TMO_MS,
  localparam int unsigned MSW        = $clog2(MS_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_start_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [19:0]       req_addr_i,
  input  logic              req_write_i,
  input  logic              req_native_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              data_rd_o,
  output logic              data_we_o,
  output logic [LEN_W-1:0]  data_idx_o,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              eng_clr_o,
  output logic              eng_buf_we_o,
  output logic [IW-1:0]     eng_buf_idx_o,
  output logic [7:0]        eng_buf_wdata_o,
  input  logic [7:0]        eng_buf_rdata_i,
  output logic [7:0]        eng_addr_lo_o,
  output logic [7:0]        eng_addr_mid_o,
  output logic [3:0]        eng_addr_hi_o,
  output logic [7:0]        eng_cmd_o,
  output logic              eng_launch_o,
  input  logic              eng_busy_i,
  input  logic              eng_reply_i,
  output logic              eng_reply_clr_o,
  input  logic              eng_err_i,
  output logic              eng_err_clr_o,
  input  logic [3:0]        eng_status_i
);
  seq_state_e        state_q, state_d;
  logic [IW-1:0]     idx_q;
  logic              wr_q, nat_q;
  logic              ck_load, ck_adv, ck_last;
  logic [LEN_W-1:0]  ck_rem, ck_base;
  logic [ADDR_W-1:0] ck_addr;
  logic [CW-1:0]     ck_clen;
  logic              tmr_clr, tmr_exp;
  logic [MSW-1:0]    tmr_limit;
  logic              try_clr, try_inc, try_last;
  logic              byte_last, attempt_bad;

  aux_chunk_track #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) i_chunk (
    .clk_i, .rst_ni, .load_i(ck_load), .len_i(req_len_i), .addr_i(req_addr_i),
    .adv_i(ck_adv), .rem_o(ck_rem), .addr_o(ck_addr), .base_o(ck_base),
    .clen_o(ck_clen), .last_o(ck_last)
  );

  aux_ms_timer #(.TICK_CYC(TICK_CYC), .MS_MAX(MS_MAX)) i_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .limit_i(tmr_limit), .expired_o(tmr_exp)
  );

  aux_retry_ctr #(.MAX_TRY(MAX_TRY)) i_try (
    .clk_i, .rst_ni, .clr_i(try_clr), .inc_i(try_inc), .last_o(try_last)
  );

  assign byte_last   = CW'(idx_q) == ck_clen - CW'(1);
  assign attempt_bad = eng_err_i || (eng_status_i != 4'h0);
  assign tmr_limit   = (state_q == S_WAIT_EN) ? MSW'(EN_TMO_MS) : MSW'(RPLY_TMO_MS);
  assign tmr_clr     = (state_q == S_LAUNCH) || (state_q == S_WAIT_EN && !eng_busy_i);

  always_comb begin
    state_d = state_q;
    ck_load = 1'b0;
    ck_adv  = 1'b0;
    try_clr = 1'b0;
    try_inc = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_start_i) begin
        ck_load = 1'b1;
        try_clr = 1'b1;
        state_d = (req_len_i == '0) ? S_DONE : S_CLEAR;
      end
      S_CLEAR:     state_d = wr_q ? S_LOAD : S_LAUNCH;
      S_LOAD:      if (byte_last) state_d = S_LAUNCH;
      S_LAUNCH:    state_d = S_WAIT_EN;
      S_WAIT_EN:   if (!eng_busy_i) state_d = S_WAIT_RPLY;
                   else if (tmr_exp) state_d = S_RETRY;
      S_WAIT_RPLY: if (eng_reply_i) state_d = S_CHECK;
                   else if (tmr_exp) state_d = S_RETRY;
      S_CHECK:     state_d = attempt_bad ? S_RETRY : (wr_q ? S_ADV : S_COPY);
      S_COPY:      if (byte_last) state_d = S_ADV;
      S_ADV: begin
        ck_adv  = 1'b1;
        try_clr = 1'b1;
        state_d = ck_last ? S_DONE : S_CLEAR;
      end
      S_RETRY: if (try_last) state_d = S_FAIL;
               else begin
                 try_inc = 1'b1;
                 state_d = S_CLEAR;
               end
      S_DONE, S_FAIL: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      wr_q    <= 1'b0;
      nat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_start_i) begin
        wr_q  <= req_write_i;
        nat_q <= req_native_i;
      end
      if (state_q == S_CLEAR || state_q == S_CHECK) idx_q <= '0;
      else if (state_q == S_LOAD || state_q == S_COPY) idx_q <= idx_q + 1'b1;
    end
  end

  assign busy_o          = state_q != S_IDLE;
  assign done_o          = state_q == S_DONE;
  assign err_o           = state_q == S_FAIL;
  assign data_rd_o       = state_q == S_LOAD;
  assign data_we_o       = state_q == S_COPY;
  assign data_idx_o      = ck_base + LEN_W'(idx_q);
  assign data_o          = eng_buf_rdata_i;
  assign eng_clr_o       = state_q == S_CLEAR;
  assign eng_buf_we_o    = state_q == S_LOAD;
  assign eng_buf_idx_o   = idx_q;
  assign eng_buf_wdata_o = data_i;
  assign eng_addr_lo_o   = ck_addr[7:0];
  assign eng_addr_mid_o  = ck_addr[15:8];
  assign eng_addr_hi_o   = ck_addr[19:16];
  assign eng_cmd_o       = aux_cmd(4'(ck_clen - CW'(1)), nat_q, ~wr_q);
  assign eng_launch_o    = state_q == S_LAUNCH;
  assign eng_reply_clr_o = state_q == S_CHECK;
  assign eng_err_clr_o   = (state_q == S_CHECK) && eng_err_i;

  // R9
  pulse_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> busy_o);
  // R10
  zero_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_start_i && req_len_i == '0) |=> done_o);
  // R7
  launch_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_launch_o |-> ck_rem != '0);
  // R6
  err_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_clr_o |-> (eng_reply_clr_o && eng_err_i));
  // R8
  copy_after_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_o && !$past(data_we_o)) |->
      ($past(eng_reply_clr_o) && !$past(eng_err_i) && $past(eng_status_i) == 4'h0));
endmodule

// File: tb/test_aux_burst_seq.sv
module test_aux_burst_seq;
  localparam int unsigned LEN_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             req_start = 1'b0, req_write = 1'b0, req_native = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [19:0]      req_addr = '0;
  logic             busy_o, done_o, err_o, data_rd_o, data_we_o;
  logic [LEN_W-1:0] data_idx_o;
  logic [7:0]       data_i, data_o;
  logic             eng_clr_o, eng_buf_we_o, eng_launch_o, eng_reply_clr_o, eng_err_clr_o;
  logic [3:0]       eng_buf_idx_o, eng_addr_hi_o;
  logic [7:0]       eng_buf_wdata_o, eng_buf_rdata_i, eng_addr_lo_o, eng_addr_mid_o, eng_cmd_o;
  logic             m_busy, m_reply, m_err;
  logic [3:0]       m_status;

  logic [7:0] src [64];
  logic [7:0] dst [64];
  logic [7:0] sink [1024];
  logic [7:0] snap [1024];
  logic [7:0] ebuf [16];

  int vectors = 0, miscompares = 0;
  int fail_left = 0, fail_kind = 0, launches = 0, done_cnt = 0;
  int exp_rem = 0, exp_off = 0;
  logic [19:0] exp_addr = '0;
  bit exp_wr = 0, exp_nat = 0, seen_clr = 0;

  aux_burst_seq #(.LEN_W(LEN_W), .TICK_CYC(8)) i_aux_burst_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_start_i(req_start), .req_len_i(req_len), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_native_i(req_native),
    .busy_o, .done_o, .err_o, .data_rd_o, .data_we_o, .data_idx_o, .data_i, .data_o,
    .eng_clr_o, .eng_buf_we_o, .eng_buf_idx_o, .eng_buf_wdata_o, .eng_buf_rdata_i,
    .eng_addr_lo_o, .eng_addr_mid_o, .eng_addr_hi_o, .eng_cmd_o, .eng_launch_o,
    .eng_busy_i(m_busy), .eng_reply_i(m_reply), .eng_reply_clr_o,
    .eng_err_i(m_err), .eng_err_clr_o, .eng_status_i(m_status)
  );

  assign data_i          = src[data_idx_o[5:0]];
  assign eng_buf_rdata_i = ebuf[eng_buf_idx_o];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (data_we_o) dst[data_idx_o[5:0]] <= data_o;
  always @(posedge clk) if (done_o) done_cnt++;

  // engine model: kind 0 ok, 1 error flag, 2 bad status, 3 enable stuck, 4 no reply
  int kind = 0, cnt = 0, phase = 0, cur_len = 0;
  logic [19:0] cur_addr;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_reply <= 1'b0; m_err <= 1'b0; m_status <= 4'h0;
      phase = 0;
    end else begin
      if (eng_clr_o) begin
        for (int k = 0; k < 16; k++) ebuf[k] <= 8'h00;
        seen_clr = 1;
      end
      if (eng_buf_we_o) ebuf[eng_buf_idx_o] <= eng_buf_wdata_o;
      if (eng_reply_clr_o) m_reply <= 1'b0;
      if (eng_err_clr_o) m_err <= 1'b0;
      if (eng_launch_o) begin
        int clen;
        int bad;
        logic [7:0] ecmd;
        launches++;
        clen = (exp_rem > 16) ? 16 : exp_rem;
        ecmd = {4'(clen - 1), exp_nat, 2'b00, ~exp_wr};
        chk(seen_clr, "R4 clear before launch", int'(seen_clr), 1);
        chk({eng_addr_hi_o, eng_addr_mid_o, eng_addr_lo_o} == exp_addr, "R2 address fields",
            int'({eng_addr_hi_o, eng_addr_mid_o, eng_addr_lo_o}), int'(exp_addr));
        chk(eng_cmd_o == ecmd, "R1,R3 command byte", int'(eng_cmd_o), int'(ecmd));
        if (exp_wr) begin
          bad = -1;
          for (int k = 0; k < clen; k++) if (ebuf[k] != src[exp_off + k] && bad < 0) bad = k;
          chk(bad < 0, "R4 write buffer contents", bad, -1);
        end
        seen_clr = 0;
        cur_addr = exp_addr;
        cur_len  = clen;
        kind = (fail_left > 0) ? fail_kind : 0;
        if (fail_left > 0) fail_left--;
        m_busy <= 1'b1; m_reply <= 1'b0; m_err <= 1'b0; m_status <= 4'h0;
        cnt = 1 + int'($urandom % 4);
        phase = 1;
      end else if (phase == 1) begin
        if (kind != 3) begin
          cnt--;
          if (cnt == 0) begin
            m_busy <= 1'b0;
            cnt = 1 + int'($urandom % 4);
            phase = 2;
          end
        end
      end else if (phase == 2) begin
        if (kind != 4) begin
          cnt--;
          if (cnt == 0) begin
            m_reply  <= 1'b1;
            m_err    <= (kind == 1);
            m_status <= (kind == 2) ? 4'h5 : 4'h0;
            phase = 0;
            if (kind == 0) begin
              for (int k = 0; k < cur_len; k++) begin
                if (exp_wr) sink[10'(cur_addr + 20'(k))] <= ebuf[k];
                else        ebuf[k] <= sink[10'(cur_addr + 20'(k))];
              end
              exp_addr += 20'(cur_len);
              exp_off  += cur_len;
              exp_rem  -= cur_len;
            end
          end
        end
      end
    end
  end

  task automatic run_xfer(input int len, input logic [19:0] addr, input bit wr, input bit nat,
                          input int nfail, input int fkind, input bit poke);
    bit exp_err;
    int exp_launch, d0, waited, bad;
    exp_err    = (len > 0) && (nfail >= 10);
    exp_launch = (len == 0) ? 0 : (exp_err ? 10 : (len + 15) / 16 + nfail);
    for (int k = 0; k < 64; k++) begin
      dst[k] = 8'hA5;
      src[k] = 8'($urandom);
    end
    for (int k = 0; k < 1024; k++) snap[k] = sink[k];
    exp_addr = addr; exp_rem = len; exp_off = 0; exp_wr = wr; exp_nat = nat;
    fail_left = nfail; fail_kind = fkind; launches = 0; d0 = done_cnt;
    @(negedge clk);
    req_start = 1'b1; req_len = LEN_W'(len); req_addr = addr;
    req_write = wr; req_native = nat;
    @(negedge clk);
    req_start = 1'b0;
    chk(busy_o, "R9 busy after start", int'(busy_o), 1);
    if (len == 0) chk(done_o, "R10 zero length done next cycle", int'(done_o), 1);
    waited = 0;
    while (!(done_o || err_o) && waited < 20000) begin
      if (poke && waited == 5) begin
        req_start = 1'b1; req_len = '0;
      end else req_start = 1'b0;
      @(negedge clk);
      waited++;
    end
    req_start = 1'b0;
    chk(done_o == !exp_err, "R7,R9 done pulse", int'(done_o), int'(!exp_err));
    chk(err_o == exp_err, "R7 error pulse", int'(err_o), int'(exp_err));
    chk(launches == exp_launch, "R7 launch count", launches, exp_launch);
    @(negedge clk);
    chk(!busy_o, "R9 busy drops after pulse", int'(busy_o), 0);
    chk(done_cnt - d0 == (exp_err ? 0 : 1), "R11 one done per transfer", done_cnt - d0,
        exp_err ? 0 : 1);
    bad = -1;
    if (wr && !exp_err) begin
      for (int k = 0; k < len; k++) if (sink[10'(addr + 20'(k))] != src[k] && bad < 0) bad = k;
      chk(bad < 0, "R2 write data at sink", bad, -1);
    end else if (wr) begin
      for (int k = 0; k < 1024; k++) if (sink[k] != snap[k] && bad < 0) bad = k;
      chk(bad < 0, "R7 failed write leaves sink", bad, -1);
    end else if (!exp_err) begin
      for (int k = 0; k < len; k++) if (dst[k] != sink[10'(addr + 20'(k))] && bad < 0) bad = k;
      chk(bad < 0, "R8 read data delivered", bad, -1);
    end else begin
      for (int k = 0; k < 64; k++) if (dst[k] != 8'hA5 && bad < 0) bad = k;
      chk(bad < 0, "R8 no copy from failed reads", bad, -1);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 1024; k++) sink[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !eng_launch_o, "R9 reset state",
        int'({busy_o, done_o, err_o, eng_launch_o}), 0);
    run_xfer(0, 20'h00123, 1, 1, 0, 0, 0);          // R10
    run_xfer(16, 20'h00040, 0, 1, 0, 0, 0);         // R1 exact chunk
    run_xfer(17, 20'h00100, 1, 0, 0, 0, 0);         // R1 one-byte tail
    run_xfer(33, 20'h0FFF8, 1, 1, 0, 0, 0);         // R2 field carry
    run_xfer(33, 20'h0FFF8, 0, 0, 0, 0, 0);
    run_xfer(20, 20'h00200, 0, 1, 9, 1, 0);         // R6 error flag, 10th try wins
    run_xfer(5, 20'h00300, 1, 1, 10, 2, 0);         // R6,R7 status abort
    run_xfer(8, 20'h00310, 0, 1, 10, 3, 0);         // R5 enable timeout abort
    run_xfer(12, 20'h00320, 0, 0, 2, 4, 0);         // R5 reply timeout
    run_xfer(40, 20'h00400, 1, 0, 0, 0, 1);         // R11 start while busy
    for (int n = 0; n < 24; n++) begin
      int nf;
      nf = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0;
      run_xfer(int'($urandom % 49), 20'($urandom), $urandom % 2 == 1, $urandom % 2 == 1,
               nf, 1 + int'($urandom % 4), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule